// File: doc/BRIEF.md
# Bitstream Integrating Decimator

This block turns the one-bit stream from a delta-sigma or incremental modulator into a wide signed count. Every cycle on which `sample_en` is high it treats `bit_in` as a signed weight, +1 for a one and -1 for a zero. It folds that weight into a first accumulator. A second accumulator, when the build includes it, sums the updated first accumulator. A one-bit mode setting chooses which accumulator is the visible result: the first for single integration, the second for double integration. Both accumulators are two's-complement and wrap silently.

A host reaches the block over a byte-wide register bus with combinational read data.
- Address 0 returns the live low byte of the result and snapshots the whole result into a holding register.
- Addresses 1 to NB-1 return bytes of the snapshot while one is pending. Otherwise they return live bytes. NB is `RES_W/BUS_W`, which is 2 by default.
- Address NB holds the control bits. Bit 0 is the mode and bit 1 is a clear command.

A two-state readout machine tracks the snapshot. `RD_OPEN` means no snapshot is pending. `RD_HELD` means one is pending. The transitions are:
- *snapshot*: `RD_OPEN` to `RD_HELD` on a low-byte read.
- *re-snapshot*: `RD_HELD` to `RD_HELD` on another low-byte read.
- *release*: `RD_HELD` to `RD_OPEN` on a read of the top byte.
- *flush*: either state to `RD_OPEN` on a clear.

After a mode change, software issues a clear before it trusts the result.

Top module: `bitstream_decimator`

## Requirements
- R1: After reset, the result, the holding register and the mode read as zero, and the readout machine is in `RD_OPEN`.
- R2: In single mode (mode bit 0 = 0), each cycle with `sample_en` high adds 1 to the result when `bit_in` is 1 and subtracts 1 when it is 0. Cycles with `sample_en` low leave the result unchanged.
- R3: In double mode (mode bit 0 = 1), the first accumulator steps as in R2. On the same edge the second accumulator adds the first accumulator's new value, and the result is the second accumulator.
- R4: Both accumulators wrap modulo 2^RES_W with no saturation. For example, a single zero sample taken from a cleared state gives 0xFFFF.
- R5: A read at address 0 returns the current result bits [7:0] in the same cycle. It also captures the full result as it stood before that edge into the holding register, even when a sample lands on the same edge.
- R6: In `RD_HELD`, a read at address 1 returns the holding register bits [15:8] and moves the machine to `RD_OPEN`. In `RD_OPEN`, the same read returns the live result bits [15:8].
- R7: Writing address 2 with bit 1 set zeroes both accumulators and the holding register and returns the machine to `RD_OPEN`. This clear wins over a sample on the same edge.
- R8: Writing address 2 stores bit 0 as the mode, and a read of address 2 returns it in bit 0 with the other bits zero. A write with bit 1 clear leaves the accumulated value untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_en | input | 1 | Sample strobe; one integration step per high cycle |
| bit_in | input | 1 | Modulator bit: 1 = +1, 0 = -1 |
| bus_addr | input | ADDR_W | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data, valid in the cycle of `bus_rd`, zero otherwise |

## Verification
All 256 eight-bit sample patterns are applied in both modes, each from a cleared state, and the result is compared with arithmetic sums. The full sweep separates the +1 and -1 weighting and the order dependence that only double integration has. Long runs of ones push the double-mode result past 2^16 to show the wrap, and a single zero exposes the wrap downward. Reads placed on the same edge as a sample, or straddling a byte carry, show whether the snapshot is coherent. A clear placed on the same edge as a sample shows which of the two wins.

// File: rtl/decim_pkg.sv
package decim_pkg;
    typedef enum logic [0:0] {
        RD_OPEN = 1'b0,
        RD_HELD = 1'b1
    } rd_state_t;

    localparam int unsigned CLR_BIT  = 1;
    localparam int unsigned MODE_BIT = 0;
endpackage

// File: rtl/decim_datapath.sv
module decim_datapath #(
    parameter int unsigned RES_W     = 16,
    parameter bit          DOUBLE_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_en,
    input  logic             bit_in,
    input  logic             clr,
    input  logic             mode,
    output logic [RES_W-1:0] result
);
    logic [RES_W-1:0] acc1, acc1_nxt, step, acc2;

    assign step     = bit_in ? RES_W'(1) : {RES_W{1'b1}};
    assign acc1_nxt = acc1 + step;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         acc1 <= '0;
        else if (clr)       acc1 <= '0;
        else if (sample_en) acc1 <= acc1_nxt;
    end

    generate
        if (DOUBLE_EN) begin : g_second
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)         acc2 <= '0;
                else if (clr)       acc2 <= '0;
                else if (sample_en) acc2 <= acc2 + acc1_nxt;
            end
            assign result = mode ? acc2 : acc1;

            // R3: second stage sums the first stage's new value
            p_second_sum_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (sample_en && !clr) |=> (acc2 == $past(acc2) + acc1))
                else $error("R3 second accumulator step wrong");
        end else begin : g_single
            assign acc2   = '0;
            assign result = acc1;
        end
    endgenerate

    // R2: one signed step per sample
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && !clr) |=> (acc1 == $past(acc1) + ($past(bit_in) ? RES_W'(1) : {RES_W{1'b1}})))
        else $error("R2 first accumulator step wrong");

    // R2: no sample, no change
    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_en && !clr) |=> ($stable(acc1) && $stable(acc2)))
        else $error("R2 accumulators moved without sample");

    // R7: clear empties both stages
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc1 == '0 && acc2 == '0))
        else $error("R7 clear did not zero accumulators");
endmodule

// File: rtl/decim_ctrl.sv
module decim_ctrl
    import decim_pkg::*;
#(
    parameter int unsigned RES_W  = 16,
    parameter int unsigned BUS_W  = 8,
    parameter int unsigned ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic [RES_W-1:0]  result,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              clr,
    output logic              mode
);
    localparam int unsigned NB = RES_W / BUS_W;

    rd_state_t        state, state_nxt;
    logic [RES_W-1:0] hold;
    logic             ctrl_hit, latch, top_rd;

    assign ctrl_hit = bus_wr && (bus_addr == ADDR_W'(NB));
    assign clr      = ctrl_hit && bus_wdata[CLR_BIT];
    assign latch    = bus_rd && (bus_addr == '0);
    assign top_rd   = bus_rd && (bus_addr == ADDR_W'(NB - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RD_OPEN;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            RD_OPEN: if (clr) state_nxt = RD_OPEN;
                     else if (latch) state_nxt = RD_HELD;
            RD_HELD: if (clr) state_nxt = RD_OPEN;
                     else if (latch) state_nxt = RD_HELD;
                     else if (top_rd) state_nxt = RD_OPEN;
            default: state_nxt = RD_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     hold <= '0;
        else if (clr)   hold <= '0;
        else if (latch) hold <= result;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        mode <= 1'b0;
        else if (ctrl_hit) mode <= bus_wdata[MODE_BIT];
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (bus_addr == '0) bus_rdata = result[BUS_W-1:0];
            for (int k = 1; k < NB; k++) begin
                if (bus_addr == ADDR_W'(k))
                    bus_rdata = (state == RD_HELD) ? hold[k*BUS_W +: BUS_W]
                                                   : result[k*BUS_W +: BUS_W];
            end
            if (bus_addr == ADDR_W'(NB)) begin
                bus_rdata[MODE_BIT] = mode;
            end
        end
    end

    // R5: low-byte read snapshots the pre-edge result
    p_snapshot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (latch && !clr) |=> (hold == $past(result) && state == RD_HELD))
        else $error("R5 snapshot wrong");

    // R6: snapshot stays frozen until the next capture or clear
    p_hold_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch && !clr) |=> $stable(hold))
        else $error("R6 holding register changed");

    // R6: top-byte read releases a pending snapshot
    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RD_HELD && top_rd && !latch && !clr) |=> (state == RD_OPEN))
        else $error("R6 release missing");

    // R7: clear flushes snapshot and machine
    p_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (hold == '0 && state == RD_OPEN))
        else $error("R7 flush wrong");

    // R8: mode moves only on a control write
    p_mode_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_hit |=> $stable(mode))
        else $error("R8 mode changed without write");

    initial begin
        assert (ADDR_W >= $clog2(NB + 1)) else $error("ADDR_W too narrow");
    end
endmodule

// File: rtl/bitstream_decimator.sv
module bitstream_decimator #(
    parameter int unsigned RES_W     = 16,
    parameter int unsigned BUS_W     = 8,
    parameter int unsigned ADDR_W    = 2,
    parameter bit          DOUBLE_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_en,
    input  logic              bit_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata
);
    logic [RES_W-1:0] result;
    logic             clr, mode;

    decim_datapath #(.RES_W(RES_W), .DOUBLE_EN(DOUBLE_EN)) u_dp (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .bit_in(bit_in),
        .clr(clr), .mode(mode), .result(result)
    );

    decim_ctrl #(.RES_W(RES_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .result(result),
        .bus_rdata(bus_rdata), .clr(clr), .mode(mode)
    );
endmodule

// File: tb/tb_bitstream_decimator.sv
module tb_bitstream_decimator;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_en = 1'b0, bit_in = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;

    int vectors = 0, errors = 0;
    bit done = 0;
    logic [15:0] m1 = '0, m2 = '0, mhold = '0;
    logic        mmode = 1'b0, mheld = 1'b0;

    bitstream_decimator dut (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .bit_in(bit_in),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    always #5 clk = ~clk;

    function automatic logic [15:0] exp_res();
        return mmode ? m2 : m1;
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] expv);
        vectors++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic model_step(logic b);
        m1 = m1 + (b ? 16'd1 : 16'hFFFF);
        m2 = m2 + m1;
    endtask

    task automatic smp(logic b);
        @(negedge clk); sample_en = 1'b1; bit_in = b;
        @(posedge clk); #1 sample_en = 1'b0;
        model_step(b);
    endtask

    task automatic wr_ctrl(logic [7:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = d;
        @(posedge clk); #1 bus_wr = 1'b0;
        mmode = d[0];
        if (d[1]) begin m1 = '0; m2 = '0; mhold = '0; mheld = 1'b0; end
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1 bus_rd = 1'b0;
        if (a == 2'd0) begin mhold = exp_res(); mheld = 1'b1; end
        else if (a == 2'd1) mheld = 1'b0;
    endtask

    task automatic check_result(string req);
        logic [7:0]  lo, hi;
        logic [15:0] e;
        e = exp_res();
        rd(2'd0, lo);
        chk(req, {8'h00, lo}, {8'h00, e[7:0]});
        rd(2'd1, hi);
        chk(req, {8'h00, hi}, {8'h00, e[15:8]});
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            vectors++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, d); chk("R1 low", {8'h00, d}, 16'h0000);
        rd(2'd1, d); chk("R1 high", {8'h00, d}, 16'h0000);
        rd(2'd2, d); chk("R1 mode", {8'h00, d}, 16'h0000);

        // R2 / R3 exhaustive 8-bit pattern sweep in both modes
        for (int md = 0; md < 2; md++) begin
            for (int p = 0; p < 256; p++) begin
                wr_ctrl({6'd0, 1'b1, md[0]});
                for (int i = 0; i < 8; i++) smp(p[i]);
                check_result(md == 0 ? "R2 sweep" : "R3 sweep");
            end
        end

        // R2 idle cycles change nothing
        wr_ctrl(8'h02);
        smp(1'b1); smp(1'b1);
        repeat (5) @(posedge clk);
        check_result("R2 idle");

        // R4 wrap downward in single mode
        wr_ctrl(8'h02);
        smp(1'b0);
        check_result("R4 down wrap");
        chk("R4 down wrap value", exp_res(), 16'hFFFF);

        // R4 wrap upward in double mode: sum 1..400 = 80200
        wr_ctrl(8'h03);
        for (int i = 0; i < 400; i++) smp(1'b1);
        check_result("R4 up wrap");
        chk("R4 up wrap value", exp_res(), 16'(80200));

        // R8 mode readback, and mode write without clear keeps the count
        rd(2'd2, d); chk("R8 mode read", {8'h00, d}, 16'h0001);
        wr_ctrl(8'h00);
        rd(2'd2, d); chk("R8 mode read 0", {8'h00, d}, 16'h0000);
        check_result("R8 no clear");
        chk("R8 kept value", exp_res(), 16'd400);

        // R5 / R6 coherent snapshot across a byte carry
        wr_ctrl(8'h02);
        for (int i = 0; i < 255; i++) smp(1'b1);
        @(negedge clk); bus_rd = 1'b1; bus_addr = 2'd0; sample_en = 1'b1; bit_in = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); #1 bus_rd = 1'b0; sample_en = 1'b0;
        chk("R5 live low", {8'h00, d}, 16'h00FF);
        mhold = exp_res(); mheld = 1'b1; model_step(1'b1);
        rd(2'd1, d); chk("R6 held high", {8'h00, d}, 16'h0000);
        rd(2'd1, d); chk("R6 open high live", {8'h00, d}, 16'h0001);

        // R7 clear beats simultaneous sample, and flushes snapshot
        rd(2'd0, d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 8'h02;
        sample_en = 1'b1; bit_in = 1'b1;
        @(posedge clk); #1 bus_wr = 1'b0; sample_en = 1'b0;
        m1 = '0; m2 = '0; mhold = '0; mheld = 1'b0; mmode = 1'b0;
        rd(2'd1, d); chk("R7 flushed high", {8'h00, d}, 16'h0000);
        rd(2'd0, d); chk("R7 cleared low", {8'h00, d}, 16'h0000);

        done = 1;
        finish_run();
    end
endmodule